// File: doc/BRIEF.md
# Character Bank Number Registers

This block keeps eight bank numbers, eight bits each, one for each of the eight 1 KB windows of character memory. A CPU loads them through a write-only port four bits at a time. Every register has a low-nibble port and a high-nibble port, and a single write changes only one nibble. The bank numbers leave the block continuously on one flat output bus, where downstream address logic can use them.

The registers are grouped in pairs across four 4 KB pages, 0xB000 to 0xE000. Each page holds two neighbouring registers. Most nibble ports answer at two offsets inside the page. This lets one decoder serve boards that select registers with address lines A1/A0 and boards that use A3/A2.

Top module: `chr_bank_regs`

## Requirements
- R1: While `rst` is high at a clock edge, bank i is loaded with the value i, for i from 0 to 7. Bank i is `bank_o[8*i+7 : 8*i]`.
- R2: Page 0xB000 serves banks 0 and 1, 0xC000 serves banks 2 and 3, 0xD000 serves banks 4 and 5, and 0xE000 serves banks 6 and 7. Call the lower bank of a page 2k and the upper one 2k+1.
- R3: Offset 0x0 within a page writes the low nibble, bits 3:0, of bank 2k.
- R4: Offsets 0x1 and 0x4 both write the high nibble, bits 7:4, of bank 2k.
- R5: Offsets 0x2 and 0x8 both write the low nibble of bank 2k+1.
- R6: Offsets 0x3 and 0xC both write the high nibble of bank 2k+1.
- R7: A nibble write stores `wr_data[3:0]`. `wr_data[7:4]` has no effect, and the other nibble of the target bank keeps its value.
- R8: A write does not change any bank when its address misses. An address misses when its top four bits are outside 0xB to 0xE, when bits 11:4 are not zero, or when the offset is 0x5, 0x6, 0x7, 0x9, 0xA, 0xB, 0xD, 0xE or 0xF.
- R9: While `wr_en` is low, no bank changes, whatever the address and data are.
- R10: A write that `wr_en` qualifies at a rising clock edge shows on `bank_o` right after that edge. The other banks do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data; only bits 3:0 are stored |
| bank_o | output | 64 | Eight bank numbers, bank i in bits 8*i+7:8*i |

## Verification
The bench uses the default parameters: sixteen address bits, eight banks and a base page of 0xB. With these values the whole space of page and offset, 16 by 16, is small enough to sweep completely. Every address in that grid is written once, in order. After each write the bench compares all eight banks with a model computed from the offset table, so both the aliased offsets and every unmatched offset on every page are covered. Further passes set bits 11:4, drop the write strobe on hitting addresses, and apply a second reset after the sweep.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        NIB_NONE = 2'd0,
        NIB_LO   = 2'd1,
        NIB_HI   = 2'd2
    } nib_sel_e;

    typedef struct packed {
        nib_sel_e sel;   // which nibble the offset targets
        logic     upper; // 0: bank 2k, 1: bank 2k+1
    } off_dec_t;

    // Offset within a page -> nibble target (aliases folded together)
    function automatic off_dec_t decode_offset(input logic [NIB_W-1:0] off);
        off_dec_t r;
        r.sel   = NIB_NONE;
        r.upper = 1'b0;
        unique case (off)
            4'h0:        begin r.sel = NIB_LO; r.upper = 1'b0; end
            4'h1, 4'h4:  begin r.sel = NIB_HI; r.upper = 1'b0; end
            4'h2, 4'h8:  begin r.sel = NIB_LO; r.upper = 1'b1; end
            4'h3, 4'hC:  begin r.sel = NIB_HI; r.upper = 1'b1; end
            default:     begin r.sel = NIB_NONE; r.upper = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chr_addr_decode.sv
module chr_addr_decode
    import chr_bank_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_BANKS = 8,
    parameter logic [3:0]  BASE_PAGE = 4'hB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic [NUM_BANKS-1:0] wr_lo,
    output logic [NUM_BANKS-1:0] wr_hi
);
    localparam int NUM_PAGES = NUM_BANKS / 2;
    localparam int PAIR_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int MID_W     = ADDR_W - 8;

    logic [3:0]       page;
    logic [3:0]       page_rel;
    logic [MID_W-1:0] mid;
    logic             page_hit;
    off_dec_t         od;
    logic [PAIR_W-1:0] pair;

    always_comb begin
        page     = wr_addr[ADDR_W-1 -: 4];
        mid      = wr_addr[ADDR_W-5:4];
        page_rel = page - BASE_PAGE;
        page_hit = (page >= BASE_PAGE) && (page_rel < 4'(NUM_PAGES)) && (mid == '0);
        od       = decode_offset(wr_addr[3:0]);
        pair     = page_rel[PAIR_W-1:0];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        localparam int PAIR_IDX = b / 2;
        localparam logic IS_UPPER = (b % 2) == 1;
        logic sel_me;
        assign sel_me  = wr_en && page_hit && (int'(pair) == PAIR_IDX) && (od.upper == IS_UPPER);
        assign wr_lo[b] = sel_me && (od.sel == NIB_LO);
        assign wr_hi[b] = sel_me && (od.sel == NIB_HI);
    end

    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_lo, wr_hi}));

    // R9
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ({wr_lo, wr_hi} == '0));

endmodule

// File: rtl/chr_bank_reg.sv
module chr_bank_reg
    import chr_bank_pkg::*;
#(
    parameter int BANK_W = 2 * NIB_W,
    parameter int INIT   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [NIB_W-1:0]  din,
    output logic [BANK_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= BANK_W'(INIT);
        end else if (wr_lo) begin
            q[NIB_W-1:0] <= din;
        end else if (wr_hi) begin
            q[BANK_W-1:NIB_W] <= din;
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (q == BANK_W'(INIT)));

    // R3
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (q[NIB_W-1:0] == $past(din)) && (q[BANK_W-1:NIB_W] == $past(q[BANK_W-1:NIB_W])));

    // R4
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (q[BANK_W-1:NIB_W] == $past(din)) && (q[NIB_W-1:0] == $past(q[NIB_W-1:0])));

endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_bank_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         NUM_BANKS = 8,
    parameter logic [3:0] BASE_PAGE = 4'hB
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [2*NIB_W-1:0]            wr_data,
    output logic [NUM_BANKS*2*NIB_W-1:0]  bank_o
);
    localparam int BANK_W = 2 * NIB_W;

    logic [NUM_BANKS-1:0] wr_lo;
    logic [NUM_BANKS-1:0] wr_hi;
    logic                 unused_data_hi;

    assign unused_data_hi = ^wr_data[BANK_W-1:NIB_W];

    chr_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BASE_PAGE (BASE_PAGE)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        chr_bank_reg #(
            .BANK_W (BANK_W),
            .INIT   (b)
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_lo (wr_lo[b]),
            .wr_hi (wr_hi[b]),
            .din   (wr_data[NIB_W-1:0]),
            .q     (bank_o[b*BANK_W +: BANK_W])
        );
    end

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_o));

    // R10
    single_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ($countones(bank_o ^ $past(bank_o)) <= NIB_W));

endmodule

// File: tb/chr_bank_regs_tb.sv
module chr_bank_regs_tb;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [63:0] bank_o;

    logic [7:0]  model [NB];
    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    chr_bank_regs u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_o  (bank_o)
    );

    task automatic model_reset();
        for (int i = 0; i < NB; i++) model[i] = 8'(i);
    endtask

    // Apply the requirements to the model
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        int pg;
        int bank;
        int hi;
        pg = int'(a[15:12]) - 11;
        if (pg < 0 || pg > 3 || a[11:4] != 8'h00) return;          // R2 / R8
        case (a[3:0])
            4'h0:       begin bank = 2*pg;   hi = 0; end            // R3
            4'h1, 4'h4: begin bank = 2*pg;   hi = 1; end            // R4
            4'h2, 4'h8: begin bank = 2*pg+1; hi = 0; end            // R5
            4'h3, 4'hC: begin bank = 2*pg+1; hi = 1; end            // R6
            default:    return;                                     // R8
        endcase
        if (hi == 1) model[bank][7:4] = d[3:0];                     // R7
        else         model[bank][3:0] = d[3:0];
    endtask

    task automatic check_all(input string req);
        n_vec++;
        for (int i = 0; i < NB; i++) begin
            if (bank_o[i*8 +: 8] !== model[i]) begin
                n_fail++;
                $display("FAIL %s bank %0d actual %02h expected %02h (addr %04h)",
                         req, i, bank_o[i*8 +: 8], model[i], wr_addr);
                break;
            end
        end
    endtask

    // One write cycle; check after the capturing edge (R10)
    task automatic do_write(input logic en, input logic [15:0] a,
                            input logic [7:0] d, input string req);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        if (en) model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check_all(req);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset values");

        // Full page x offset sweep: R2..R8, R10
        for (int p = 0; p < 16; p++) begin
            for (int o = 0; o < 16; o++) begin
                logic [7:0] d;
                d = 8'(((p * 16 + o) * 7 + 3)) ^ 8'h5A;
                do_write(1'b1, {4'(p), 8'h00, 4'(o)}, d, "R2-sweep R3 R4 R5 R6 R7 R8 R10");
            end
        end

        // Nonzero middle bits must miss: R8
        for (int p = 11; p < 15; p++) begin
            for (int o = 0; o < 16; o++) begin
                do_write(1'b1, {4'(p), 8'(1 << (o % 8)), 4'(o)}, 8'(o * 17 + 1), "R8 mid bits");
            end
        end

        // Hitting addresses with wr_en low: R9
        for (int p = 11; p < 15; p++) begin
            for (int o = 0; o < 5; o++) begin
                do_write(1'b0, {4'(p), 8'h00, 4'(o)}, 8'hFF ^ 8'(o), "R9 no strobe");
            end
        end

        // High data nibble ignored: R7
        do_write(1'b1, 16'hE000, 8'hF3, "R7 data hi ignored");
        do_write(1'b1, 16'hE00C, 8'h09, "R7 other nibble kept");

        // Second reset: R1
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 re-reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule